// File: doc/BRIEF.md
# ATA Programmed-I/O and Multiword-DMA Strobe Timing Generator

This block drives the active-low read and write strobes of one parallel ATA channel for programmed I/O and multiword DMA cycles. Each cycle has three phases: an optional setup phase, an active phase with the strobe asserted, and a recovery phase with the strobe released. The length of each phase comes from a 32-bit timing word. Data-port accesses and task-file register accesses each have their own set of fields in that word. Active and recovery fields hold the cycle count minus one. Setup fields hold the cycle count itself, so a setup field of zero skips the setup phase.

The timing word lives in a configuration register that is written through a masked update port. A programmed-I/O update changes only the bits covered by mask 0xCFC3FFFF. A multiword-DMA update changes only the bits covered by mask 0x31C001FF. All other bits keep their value. The sequencer copies the phase lengths it needs when it accepts a start. A rewrite during a transfer therefore applies from the next accepted start onward.

A start asserted in the final recovery cycle chains a new cycle. That cycle goes directly into its active phase and has no setup phase. A one-clock done pulse marks the last recovery cycle of every access.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset both strobes are high, done and busy are low, and the configuration word is zero.
- R2: A data access (reg_acc=0) accepted from idle runs as follows. First comes a setup phase of word[24:22] cycles, skipped when that field is 0. Next comes an active phase of word[8:4]+1 cycles. Last comes a recovery phase of word[3:0]+1 cycles.
- R3: A task-file access (reg_acc=1) takes its setup from word[27:25], its active time from word[17:13]+1 and its recovery from word[12:9]+1. It ignores the data fields.
- R4: When wr=1 only wr_n is driven low in the active phase; when wr=0 only rd_n is driven low. The other strobe stays high for the whole access.
- R5: done is high for exactly one clock, in the last recovery cycle, while both strobes are high. In the next cycle busy is low unless a chain was requested.
- R6: When start is high during the done cycle, the following cycle is already the active phase of a new access, with no setup phase.
- R7: A start that arrives while busy, outside the done cycle, is ignored. The block returns to idle after the current access.
- R8: An update with upd_dma=0 sets cfg_q to (old & ~0xCFC3FFFF) | (upd_word & 0xCFC3FFFF), visible one clock later.
- R9: An update with upd_dma=1 sets cfg_q to (old & ~0x31C001FF) | (upd_word & 0x31C001FF), visible one clock later.
- R10: Phase lengths are captured when a start is accepted. An update during a transfer leaves that transfer unchanged and governs the next one.
- R11: dma_en reflects cfg_q[29], bus_master reflects cfg_q[30] and fifo_en reflects cfg_q[31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one access (accepted when idle or in the done cycle) |
| reg_acc | input | 1 | 1 = task-file register access, 0 = data access |
| wr | input | 1 | 1 = write strobe, 0 = read strobe |
| upd_en | input | 1 | Apply a masked update to the configuration word |
| upd_dma | input | 1 | Update mask select: 0 = PIO mask, 1 = multiword-DMA mask |
| upd_word | input | 32 | New timing word for the update |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock pulse in the last recovery cycle |
| busy | output | 1 | An access is in progress |
| cfg_q | output | 32 | Current configuration word |
| dma_en | output | 1 | Multiword DMA enabled |
| bus_master | output | 1 | Bus-master operation during PIO |
| fifo_en | output | 1 | PIO FIFO enabled |

## Verification
The strobes and done are decoded from registered phase state. The sample taken one clock after the edge that accepts a start therefore already shows the first setup cycle, or the first active cycle when setup is zero. The bench counts strobe-high, strobe-low and post-strobe samples up to and including the done sample, and compares them with setup, active+1 and recovery+1. An update of cfg_q and the three mode outputs is due one edge after upd_en is seen. The bench drives every input at a falling edge and reads every output at the next falling edge or later, so each sample sits half a period away from the edge that produced it.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
    localparam int WORD_W  = 32;
    localparam int SETUP_W = 3;
    localparam int ACT_W   = 5;
    localparam int REC_W   = 4;
    localparam int CNT_W   = (ACT_W > REC_W) ? ACT_W : REC_W;

    localparam logic [WORD_W-1:0] PIO_MASK = 32'hCFC3FFFF;
    localparam logic [WORD_W-1:0] DMA_MASK = 32'h31C001FF;

    localparam int BIT_DMA_EN  = 29;
    localparam int BIT_BUS_MST = 30;
    localparam int BIT_FIFO_EN = 31;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOV
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [ACT_W-1:0]   act;
        logic [REC_W-1:0]   rec;
    } phase_cfg_t;

    // Pick the field set for the access type from a packed timing word.
    function automatic phase_cfg_t select_phases(input logic [WORD_W-1:0] w,
                                                 input logic reg_acc);
        phase_cfg_t p;
        if (reg_acc) begin
            p.setup = w[27:25];
            p.act   = w[17:13];
            p.rec   = w[12:9];
        end else begin
            p.setup = w[24:22];
            p.act   = w[8:4];
            p.rec   = w[3:0];
        end
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] merge_masked(input logic [WORD_W-1:0] old_w,
                                                       input logic [WORD_W-1:0] new_w,
                                                       input logic [WORD_W-1:0] mask);
        return (old_w & ~mask) | (new_w & mask);
    endfunction
endpackage

// File: rtl/ata_strb_cfg.sv
module ata_strb_cfg
    import ata_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic              upd_dma,
    input  logic [WORD_W-1:0] upd_word,
    output logic [WORD_W-1:0] cfg_q
);
    logic [WORD_W-1:0] mask_sel;

    always_comb mask_sel = upd_dma ? DMA_MASK : PIO_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (upd_en) begin
            cfg_q <= merge_masked(cfg_q, upd_word, mask_sel);
        end
    end

    // R8
    pio_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_dma) |=> ((cfg_q & ~PIO_MASK) == ($past(cfg_q) & ~PIO_MASK)));

    // R9
    dma_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_dma) |=> ((cfg_q & ~DMA_MASK) == ($past(cfg_q) & ~DMA_MASK)));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(cfg_q));
endmodule

// File: rtl/ata_strb_seq.sv
module ata_strb_seq
    import ata_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              reg_acc,
    input  logic              wr,
    input  logic [WORD_W-1:0] cfg_word,
    output logic              rd_n,
    output logic              wr_n,
    output logic              done,
    output logic              busy
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    phase_cfg_t        cur_q;
    phase_cfg_t        picks;
    logic              wr_q;
    logic              last_cyc;

    always_comb begin
        picks    = select_phases(cfg_word, reg_acc);
        last_cyc = (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            cur_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        cur_q <= picks;
                        wr_q  <= wr;
                        if (picks.setup != '0) begin
                            phase <= PH_SETUP;
                            cnt   <= CNT_W'(picks.setup) - CNT_ONE;
                        end else begin
                            phase <= PH_ACTIVE;
                            cnt   <= CNT_W'(picks.act);
                        end
                    end
                end
                PH_SETUP: begin
                    if (last_cyc) begin
                        phase <= PH_ACTIVE;
                        cnt   <= CNT_W'(cur_q.act);
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                PH_ACTIVE: begin
                    if (last_cyc) begin
                        phase <= PH_RECOV;
                        cnt   <= CNT_W'(cur_q.rec);
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                PH_RECOV: begin
                    if (last_cyc) begin
                        if (start) begin
                            cur_q <= picks;
                            wr_q  <= wr;
                            phase <= PH_ACTIVE;
                            cnt   <= CNT_W'(picks.act);
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_n = !((phase == PH_ACTIVE) && !wr_q);
        wr_n = !((phase == PH_ACTIVE) && wr_q);
        done = (phase == PH_RECOV) && last_cyc;
        busy = (phase != PH_IDLE);
    end

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_n && wr_n));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R6
    chain_active_chk: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (!rd_n || !wr_n));
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
    import ata_strobe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        reg_acc,
    input  logic        wr,
    input  logic        upd_en,
    input  logic        upd_dma,
    input  logic [31:0] upd_word,
    output logic        rd_n,
    output logic        wr_n,
    output logic        done,
    output logic        busy,
    output logic [31:0] cfg_q,
    output logic        dma_en,
    output logic        bus_master,
    output logic        fifo_en
);
    logic [WORD_W-1:0] cfg_w;

    ata_strb_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (upd_en),
        .upd_dma  (upd_dma),
        .upd_word (upd_word),
        .cfg_q    (cfg_w)
    );

    ata_strb_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .reg_acc  (reg_acc),
        .wr       (wr),
        .cfg_word (cfg_w),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .done     (done),
        .busy     (busy)
    );

    always_comb begin
        cfg_q      = cfg_w;
        dma_en     = cfg_w[BIT_DMA_EN];
        bus_master = cfg_w[BIT_BUS_MST];
        fifo_en    = cfg_w[BIT_FIFO_EN];
    end

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (rd_n && wr_n && !done));
endmodule

// File: tb/test_ata_strobe_gen.sv
module test_ata_strobe_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        start, reg_acc, wr, upd_en, upd_dma;
    logic [31:0] upd_word;
    logic        rd_n, wr_n, done, busy, dma_en, bus_master, fifo_en;
    logic [31:0] cfg_q;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_cfg = '0;

    always #5 clk = ~clk;

    ata_strobe_gen i_ata_strobe_gen (
        .clk(clk), .rst(rst), .start(start), .reg_acc(reg_acc), .wr(wr),
        .upd_en(upd_en), .upd_dma(upd_dma), .upd_word(upd_word),
        .rd_n(rd_n), .wr_n(wr_n), .done(done), .busy(busy), .cfg_q(cfg_q),
        .dma_en(dma_en), .bus_master(bus_master), .fifo_en(fifo_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int ds, input int da, input int dr,
                                       input int ts, input int ta, input int tr);
        logic [31:0] w;
        w = '0;
        w[3:0]   = 4'(dr);
        w[8:4]   = 5'(da);
        w[12:9]  = 4'(tr);
        w[17:13] = 5'(ta);
        w[24:22] = 3'(ds);
        w[27:25] = 3'(ts);
        return w;
    endfunction

    task automatic upd(input bit dma, input logic [31:0] w);
        logic [31:0] m;
        m = dma ? 32'h31C001FF : 32'hCFC3FFFF;
        @(negedge clk);
        upd_en = 1'b1; upd_dma = dma; upd_word = w;
        @(negedge clk);
        upd_en = 1'b0;
        exp_cfg = (exp_cfg & ~m) | (w & m);
        chk(cfg_q == exp_cfg, dma ? "R9 dma-masked update" : "R8 pio-masked update",
            int'(cfg_q), int'(exp_cfg));
    endtask

    task automatic run_xfer(input bit tf, input bit w_r, input int es, input int ea,
                            input int er, input int poke_idx, input int upd_idx,
                            input logic [31:0] upd_w, input string tag);
        int pre, lo, post, ph;
        bit quiet, got_done, s, o;
        pre = 0; lo = 0; post = 0; ph = 0; quiet = 1; got_done = 0;
        @(negedge clk);
        reg_acc = tf; wr = w_r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 300; k++) begin
            s = w_r ? wr_n : rd_n;
            o = w_r ? rd_n : wr_n;
            if (!o) quiet = 0;
            if (ph == 0) begin
                if (s) pre++; else begin ph = 1; lo++; end
            end else if (ph == 1) begin
                if (!s) lo++; else begin ph = 2; post++; end
            end else begin
                post++;
            end
            if (done) begin got_done = 1; break; end
            start    = (k == poke_idx);
            upd_en   = (k == upd_idx);
            upd_dma  = 1'b0;
            upd_word = upd_w;
            @(negedge clk);
        end
        start = 1'b0; upd_en = 1'b0;
        chk(got_done, {tag, " done seen"}, int'(got_done), 1);
        chk(pre == es, {tag, " setup cycles"}, pre, es);
        chk(lo == ea, {tag, " active cycles"}, lo, ea);
        chk(post == er, {tag, " recovery cycles"}, post, er);
        chk(quiet, "R4 other strobe stays high", int'(quiet), 1);
        @(negedge clk);
        chk(!done && !busy && rd_n && wr_n, "R5 one-clock done then idle",
            int'({done, busy, rd_n, wr_n}), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int sv[4] = '{0, 1, 3, 7};
        int av[4] = '{0, 1, 5, 31};
        int rv[3] = '{0, 2, 15};
        int tsv[3] = '{0, 2, 7};
        int tav[3] = '{0, 3, 31};
        int trv[3] = '{0, 1, 15};
        rst = 1'b1; start = 0; reg_acc = 0; wr = 0; upd_en = 0; upd_dma = 0; upd_word = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(rd_n && wr_n && !done && !busy, "R1 reset outputs",
            int'({rd_n, wr_n, done, busy}), 12);
        chk(cfg_q == 32'h0, "R1 reset cfg", int'(cfg_q), 0);

        // R2 and R4: data access sweep
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                for (int k = 0; k < 3; k++)
                    for (int b = 0; b < 2; b++) begin
                        upd(0, mk(sv[i], av[j], rv[k], 5, 7, 3));
                        run_xfer(0, b[0], sv[i], av[j] + 1, rv[k] + 1, -1, -1, '0, "R2 data");
                    end

        // R3: task-file sweep, data fields set to other values
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                for (int k = 0; k < 3; k++) begin
                    upd(0, mk(4, 9, 6, tsv[i], tav[j], trv[k]));
                    run_xfer(1, k[0], tsv[i], tav[j] + 1, trv[k] + 1, -1, -1, '0, "R3 taskfile");
                end

        // R7: extra start during the active phase is ignored
        upd(0, mk(1, 4, 3, 0, 0, 0));
        run_xfer(0, 0, 1, 5, 4, 2, -1, '0, "R7 ignored start");

        // R10: rewrite mid-transfer, current keeps old active length
        upd(0, mk(0, 20, 1, 0, 0, 0));
        run_xfer(0, 1, 0, 21, 2, -1, 3, mk(0, 2, 1, 0, 0, 0), "R10 current");
        exp_cfg = (exp_cfg & ~32'hCFC3FFFF) | (mk(0, 2, 1, 0, 0, 0) & 32'hCFC3FFFF);
        chk(cfg_q == exp_cfg, "R10 cfg took mid-transfer write", int'(cfg_q), int'(exp_cfg));
        run_xfer(0, 1, 0, 3, 2, -1, -1, '0, "R10 next");

        // R6: chained access skips setup
        begin
            int lo, post, ph;
            bit got;
            upd(0, mk(3, 2, 1, 0, 0, 0));
            @(negedge clk);
            reg_acc = 0; wr = 0; start = 1'b1;
            got = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (done) begin got = 1; break; end
            end
            chk(got, "R6 first done", int'(got), 1);
            @(negedge clk);
            start = 1'b0;
            chk(!rd_n && busy, "R6 chained access starts active at once",
                int'({rd_n, busy}), 1);
            lo = 0; post = 0; ph = 0; got = 0;
            for (int k = 0; k < 100; k++) begin
                if (ph == 0) begin
                    if (!rd_n) lo++; else begin ph = 1; post++; end
                end else post++;
                if (done) begin got = 1; break; end
                @(negedge clk);
            end
            chk(lo == 3, "R6 chained active cycles", lo, 3);
            chk(post == 2, "R6 chained recovery cycles", post, 2);
            @(negedge clk);
            chk(!busy, "R6 idle after chain", int'(busy), 0);
        end

        // R8, R9, R11: mask behaviour and mode bits
        upd(0, 32'hFFFFFFFF);
        upd(1, 32'h00000000);
        chk({fifo_en, bus_master, dma_en} == {exp_cfg[31], exp_cfg[30], exp_cfg[29]},
            "R11 mode bits a", int'({fifo_en, bus_master, dma_en}),
            int'({exp_cfg[31], exp_cfg[30], exp_cfg[29]}));
        upd(1, 32'hFFFFFFFF);
        chk({fifo_en, bus_master, dma_en} == {exp_cfg[31], exp_cfg[30], exp_cfg[29]},
            "R11 mode bits b", int'({fifo_en, bus_master, dma_en}),
            int'({exp_cfg[31], exp_cfg[30], exp_cfg[29]}));
        upd(0, 32'h0000_0000);
        chk({fifo_en, bus_master, dma_en} == 3'b001, "R11 mode bits c",
            int'({fifo_en, bus_master, dma_en}), 1);
        upd(1, 32'h5A5A_A5A5);
        upd(0, 32'hA5A5_5A5A);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule